// File: doc/BRIEF.md
# Card Data FIFO Pair with Burst Service Requests

This block sits between the data path of an SD/MMC card interface and the system side (a host bus or a DMA engine). It holds two independent 32-bit word FIFOs: a receive FIFO filled by the card side and emptied by bus reads, and a transmit FIFO filled by bus writes and emptied by the card side. Each FIFO is 16 words deep.

Each FIFO raises a service request at its half-full point, so that one request can always be followed by an 8-word burst. The receive request means at least one burst of words is waiting to be read. The transmit request means there is room for at least one burst of writes. Each FIFO also reports a status word with empty, full and almost-full bits at fixed positions, which neighbouring logic decodes. A final transfer shorter than 8 words is handled by the bus side using these flags.

Top module: `card_data_fifo_pair`

## Requirements
- R1: Each FIFO returns its words in the order they were accepted, and the two FIFOs operate independently of each other.
- R2: A FIFO accepts at most 16 words. A push to the receive FIFO or a bus write to the transmit FIFO while it holds 16 words is dropped, and the stored contents are unchanged.
- R3: `rx_dma_req` is high exactly when the receive FIFO holds 8 or more words.
- R4: `tx_dma_req` is high exactly when the transmit FIFO holds fewer than 8 words.
- R5: A read or pop from an empty FIFO leaves its pointers unchanged, and the data output keeps the last word it returned. The next word pushed is the next word read.
- R6: Each 16-bit status word has bit 6 set when the FIFO is empty, bit 7 set when it holds 16 words, and bit 10 set when it holds 15 or more words. All other bits are 0.
- R7: Read data is registered. A word appears on the data output on the clock edge that samples the read or pop strobe, and does not change before that edge.
- R8: While the synchronous active-low reset is low, both requests are low. A reset empties both FIFOs and clears both data outputs to 0.
- R9: A push and a pop in the same cycle both take effect when the FIFO is neither empty nor full, and the count is unchanged. When the FIFO is full, only the pop takes effect. When it is empty, only the push takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; empties both FIFOs |
| card_rx_push | input | 1 | Card side pushes a received word |
| card_rx_word | input | 32 | Received word from the card side |
| bus_rx_read | input | 1 | Bus side reads one word from the receive FIFO |
| bus_rx_word | output | 32 | Registered word read from the receive FIFO |
| rx_status | output | 16 | Receive FIFO status: bit 6 empty, bit 7 full, bit 10 almost full |
| rx_dma_req | output | 1 | Receive service request (8 or more words held) |
| bus_tx_write | input | 1 | Bus side writes one word to the transmit FIFO |
| bus_tx_word | input | 32 | Word written by the bus side |
| card_tx_pop | input | 1 | Card side pops one word from the transmit FIFO |
| card_tx_word | output | 32 | Registered word popped for the card side |
| tx_status | output | 16 | Transmit FIFO status: bit 6 empty, bit 7 full, bit 10 almost full |
| tx_dma_req | output | 1 | Transmit service request (fewer than 8 words held) |

## Verification
All results follow one clock edge after the strobe that causes them. The data outputs load at the edge that samples a read or pop. The status bits and both requests are decoded from the word count that the same edge updates, so they settle with no further register stage. The bench drives every strobe at a falling edge. Just before the next rising edge it checks that the data outputs still hold the values from the previous step. At the falling edge after that rising edge it compares every output against a queue model. The reset checks are made at a falling edge while reset is held low.

// File: rtl/card_fifo_pkg.sv
// Package: shared constants and types for the card data FIFO pair.
// Assumes a status word of 16 bits whose flag positions are fixed by the
// logic that decodes it.
package card_fifo_pkg;

    localparam int STAT_W    = 16;
    localparam int EMPTY_BIT = 6;
    localparam int FULL_BIT  = 7;
    localparam int AFULL_BIT = 10;

    // Which side of the threshold raises the service request.
    typedef enum logic {
        REQ_WHEN_FILLED  = 1'b0,
        REQ_WHEN_DRAINED = 1'b1
    } req_mode_e;

endpackage

// File: rtl/fifo_word_store.sv
// Module: word storage for one FIFO, with one write port and one
// asynchronous read port. Assumes the controller never writes to a
// full FIFO, and only uses the read word when the FIFO is not empty.
module fifo_word_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              wr_en_i,
    input  logic [AW-1:0]     wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [AW-1:0]     rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    logic [DATA_W-1:0] cells [DEPTH];

    // Store the accepted word at the write slot.
    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            cells[wr_addr_i] <= wr_data_i;
        end
    end

    assign rd_data_o = cells[rd_addr_i];

endmodule

// File: rtl/fifo_ptr_ctrl.sv
// Module: pointers, occupancy count and the registered output word for one
// FIFO. A push to a full FIFO is dropped. A pop from an empty FIFO keeps
// the pointers and the last output word. The full and empty tests use the
// count from before the clock edge. Reset is synchronous and active low.
module fifo_ptr_ctrl #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] rd_word_i,
    output logic              wr_en_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [AW-1:0]     rd_addr_o,
    output logic [CW-1:0]     count_o,
    output logic [DATA_W-1:0] pop_data_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] out_q;
    logic              push_ok;
    logic              pop_ok;

    // Qualify the strobes against the count from before the edge.
    always_comb begin
        push_ok = push_i && (count != FULL_CNT);
        pop_ok  = pop_i && (count != '0);
    end

    // Advance the write pointer, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (push_ok) begin
            wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Advance the read pointer, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (pop_ok) begin
            rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Track occupancy; a push and a pop together leave it unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Register the popped word; hold it when nothing is popped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (pop_ok) begin
            out_q <= rd_word_i;
        end
    end

    assign wr_en_o    = push_ok;
    assign wr_addr_o  = wr_ptr;
    assign rd_addr_o  = rd_ptr;
    assign count_o    = count;
    assign pop_data_o = out_q;

    // R2: occupancy never exceeds the depth
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= FULL_CNT);

    // R2: a lone push into a full FIFO changes nothing
    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == FULL_CNT && push_i && !pop_i) |=> $stable(count_o) && $stable(wr_addr_o));

    // R5: a lone pop from an empty FIFO keeps the word and the pointer
    a_r5_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (count_o == '0 && pop_i && !push_i) |=> $stable(pop_data_o) && $stable(rd_addr_o));

    // R9: a push and a pop together in the middle range keep the count
    a_r9_both_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i && count_o != '0 && count_o != FULL_CNT) |=> $stable(count_o));

endmodule

// File: rtl/fifo_flag_gen.sv
// Module: decodes one FIFO's count into the status word and the service
// request. MODE picks which side of the threshold raises the request.
// Assumes the count never exceeds DEPTH. The request is held low while
// the active-low reset is low.
module fifo_flag_gen
    import card_fifo_pkg::*;
#(
    parameter int        DEPTH     = 16,
    parameter int        BURST     = 8,
    parameter int        AFULL_LVL = DEPTH - 1,
    parameter req_mode_e MODE      = REQ_WHEN_FILLED,
    localparam int       CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     count_i,
    output logic [STAT_W-1:0] status_o,
    output logic              req_o
);

    localparam logic [CW-1:0] FULL_CNT  = CW'(DEPTH);
    localparam logic [CW-1:0] THRESH    = CW'(BURST);
    localparam logic [CW-1:0] AFULL_CNT = CW'(AFULL_LVL);

    logic level_hit;

    // Build the status word; bits with no flag read as zero.
    always_comb begin
        status_o            = '0;
        status_o[EMPTY_BIT] = (count_i == '0);
        status_o[FULL_BIT]  = (count_i == FULL_CNT);
        status_o[AFULL_BIT] = (count_i >= AFULL_CNT);
    end

    // Pick the threshold comparison for this direction.
    generate
        if (MODE == REQ_WHEN_FILLED) begin : g_fill
            assign level_hit = (count_i >= THRESH);
        end else begin : g_drain
            assign level_hit = (count_i < THRESH);
        end
    endgenerate

    // Hold the request low while reset is applied.
    always_comb begin
        req_o = rst_n && level_hit;
    end

    // R8: no service request while reset is held
    a_r8_req_quiet: assert property (@(posedge clk)
        !rst_n |-> !req_o);

    // R6: a full FIFO also reports almost full
    a_r6_full_implies_afull: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[FULL_BIT] |-> status_o[AFULL_BIT]);

endmodule

// File: rtl/card_data_fifo_pair.sv
// Module: receive and transmit word FIFOs between a card data path and a
// bus or DMA engine. Channel 0 receives: the card pushes, the bus reads,
// and the request means words are waiting. Channel 1 transmits: the bus
// writes, the card pops, and the request means there is room. Reset is
// synchronous and active low.
module card_data_fifo_pair
    import card_fifo_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int DEPTH     = 16,
    parameter int BURST     = 8,
    parameter int AFULL_LVL = DEPTH - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rx_push,
    input  logic [DATA_W-1:0] card_rx_word,
    input  logic              bus_rx_read,
    output logic [DATA_W-1:0] bus_rx_word,
    output logic [STAT_W-1:0] rx_status,
    output logic              rx_dma_req,
    input  logic              bus_tx_write,
    input  logic [DATA_W-1:0] bus_tx_word,
    input  logic              card_tx_pop,
    output logic [DATA_W-1:0] card_tx_word,
    output logic [STAT_W-1:0] tx_status,
    output logic              tx_dma_req
);

    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(DEPTH + 1);
    localparam int NCHAN  = 2;
    localparam int RX_IDX = 0;
    localparam int TX_IDX = 1;

    logic [NCHAN-1:0]  ch_push;
    logic [NCHAN-1:0]  ch_pop;
    logic [NCHAN-1:0]  ch_req;
    logic [DATA_W-1:0] ch_in   [NCHAN];
    logic [DATA_W-1:0] ch_out  [NCHAN];
    logic [STAT_W-1:0] ch_stat [NCHAN];

    // Route the port strobes and words onto the two channels.
    always_comb begin
        ch_push[RX_IDX] = card_rx_push;
        ch_pop[RX_IDX]  = bus_rx_read;
        ch_in[RX_IDX]   = card_rx_word;
        ch_push[TX_IDX] = bus_tx_write;
        ch_pop[TX_IDX]  = card_tx_pop;
        ch_in[TX_IDX]   = bus_tx_word;
    end

    generate
        for (genvar c = 0; c < NCHAN; c++) begin : g_chan
            localparam req_mode_e CH_MODE = (c == RX_IDX) ? REQ_WHEN_FILLED : REQ_WHEN_DRAINED;

            logic              wr_en;
            logic [AW-1:0]     wr_addr;
            logic [AW-1:0]     rd_addr;
            logic [CW-1:0]     count;
            logic [DATA_W-1:0] rd_word;

            fifo_ptr_ctrl #(
                .DATA_W (DATA_W),
                .DEPTH  (DEPTH)
            ) u_ctrl (
                .clk        (clk),
                .rst_n      (rst_n),
                .push_i     (ch_push[c]),
                .pop_i      (ch_pop[c]),
                .rd_word_i  (rd_word),
                .wr_en_o    (wr_en),
                .wr_addr_o  (wr_addr),
                .rd_addr_o  (rd_addr),
                .count_o    (count),
                .pop_data_o (ch_out[c])
            );

            fifo_word_store #(
                .DATA_W (DATA_W),
                .DEPTH  (DEPTH)
            ) u_store (
                .clk       (clk),
                .wr_en_i   (wr_en),
                .wr_addr_i (wr_addr),
                .wr_data_i (ch_in[c]),
                .rd_addr_i (rd_addr),
                .rd_data_o (rd_word)
            );

            fifo_flag_gen #(
                .DEPTH     (DEPTH),
                .BURST     (BURST),
                .AFULL_LVL (AFULL_LVL),
                .MODE      (CH_MODE)
            ) u_flags (
                .clk      (clk),
                .rst_n    (rst_n),
                .count_i  (count),
                .status_o (ch_stat[c]),
                .req_o    (ch_req[c])
            );
        end
    endgenerate

    // Drive the outputs from the channel results.
    always_comb begin
        bus_rx_word  = ch_out[RX_IDX];
        rx_status    = ch_stat[RX_IDX];
        rx_dma_req   = ch_req[RX_IDX];
        card_tx_word = ch_out[TX_IDX];
        tx_status    = ch_stat[TX_IDX];
        tx_dma_req   = ch_req[TX_IDX];
    end

    // R3: a receive request never coexists with an empty receive FIFO
    a_r3_rx_req_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> !rx_status[EMPTY_BIT]);

    // R4: a transmit request never coexists with a full transmit FIFO
    a_r4_tx_req_notfull: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> !tx_status[FULL_BIT]);

    // R4: an empty transmit FIFO always requests data
    a_r4_tx_empty_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_status[EMPTY_BIT] |-> tx_dma_req);

endmodule

// File: tb/card_data_fifo_pair_test.sv
`timescale 1ns/1ps
module card_data_fifo_pair_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        card_rx_push = 1'b0;
    logic [31:0] card_rx_word = '0;
    logic        bus_rx_read = 1'b0;
    logic [31:0] bus_rx_word;
    logic [15:0] rx_status;
    logic        rx_dma_req;
    logic        bus_tx_write = 1'b0;
    logic [31:0] bus_tx_word = '0;
    logic        card_tx_pop = 1'b0;
    logic [31:0] card_tx_word;
    logic [15:0] tx_status;
    logic        tx_dma_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [31:0] q_rx [$];
    logic [31:0] q_tx [$];
    logic [31:0] exp_rx_out = '0;
    logic [31:0] exp_tx_out = '0;

    card_data_fifo_pair uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .card_rx_push (card_rx_push),
        .card_rx_word (card_rx_word),
        .bus_rx_read  (bus_rx_read),
        .bus_rx_word  (bus_rx_word),
        .rx_status    (rx_status),
        .rx_dma_req   (rx_dma_req),
        .bus_tx_write (bus_tx_write),
        .bus_tx_word  (bus_tx_word),
        .card_tx_pop  (card_tx_pop),
        .card_tx_word (card_tx_word),
        .tx_status    (tx_status),
        .tx_dma_req   (tx_dma_req)
    );

    always #2.5 clk = ~clk;

    // Expected status word: bit 6 empty, bit 7 full, bit 10 at 15 or more words.
    function automatic logic [15:0] stat_of(input int n);
        logic [15:0] s = '0;
        s[6]  = (n == 0);
        s[7]  = (n == 16);
        s[10] = (n >= 15);
        return s;
    endfunction

    task automatic chk(input string tag, input string ctx, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, ctx, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // One cycle: drive at the falling edge, check R7 before the rising edge,
    // and compare all outputs at the next falling edge.
    task automatic step(input bit rp, input logic [31:0] rw, input bit rr,
                        input bit tw, input logic [31:0] txw, input bit tp, input string ctx);
        bit rx_rd_empty, tx_pop_empty;
        card_rx_push = rp; card_rx_word = rw; bus_rx_read = rr;
        bus_tx_write = tw; bus_tx_word = txw; card_tx_pop = tp;
        #1;
        chk("R7", {ctx, " rx before edge"}, bus_rx_word, exp_rx_out);
        chk("R7", {ctx, " tx before edge"}, card_tx_word, exp_tx_out);
        rx_rd_empty  = rr && (q_rx.size() == 0);
        tx_pop_empty = tp && (q_tx.size() == 0);
        begin
            bit rx_pop_ok  = rr && (q_rx.size() > 0);
            bit rx_push_ok = rp && (q_rx.size() < 16);
            bit tx_pop_ok  = tp && (q_tx.size() > 0);
            bit tx_push_ok = tw && (q_tx.size() < 16);
            if (rx_pop_ok) exp_rx_out = q_rx.pop_front();
            if (rx_push_ok) q_rx.push_back(rw);
            if (tx_pop_ok) exp_tx_out = q_tx.pop_front();
            if (tx_push_ok) q_tx.push_back(txw);
        end
        @(posedge clk);
        @(negedge clk);
        chk(rx_rd_empty ? "R5" : "R1", {ctx, " rx word"}, bus_rx_word, exp_rx_out);
        chk(tx_pop_empty ? "R5" : "R1", {ctx, " tx word"}, card_tx_word, exp_tx_out);
        chk("R6", {ctx, " rx status"}, {16'h0, rx_status}, {16'h0, stat_of(q_rx.size())});
        chk("R6", {ctx, " tx status"}, {16'h0, tx_status}, {16'h0, stat_of(q_tx.size())});
        chk("R3", {ctx, " rx req"}, {31'h0, rx_dma_req}, {31'h0, q_rx.size() >= 8});
        chk("R4", {ctx, " tx req"}, {31'h0, tx_dma_req}, {31'h0, q_tx.size() < 8});
    endtask

    // Apply reset for two cycles and check the R8 outputs while it is held.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        card_rx_push = 0; bus_rx_read = 0; bus_tx_write = 0; card_tx_pop = 0;
        repeat (2) @(negedge clk);
        chk("R8", "req rx in reset", {31'h0, rx_dma_req}, 32'h0);
        chk("R8", "req tx in reset", {31'h0, tx_dma_req}, 32'h0);
        chk("R8", "rx word in reset", bus_rx_word, 32'h0);
        chk("R8", "tx word in reset", card_tx_word, 32'h0);
        chk("R8", "rx flushed", {16'h0, rx_status}, 32'h0040);
        chk("R8", "tx flushed", {16'h0, tx_status}, 32'h0040);
        q_rx.delete(); q_tx.delete();
        exp_rx_out = '0; exp_tx_out = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd4411));
        do_reset();
        step(0, 0, 0, 0, 0, 0, "idle after reset");

        // R2: seventeen pushes into the receive FIFO; the last one is dropped.
        for (int i = 0; i < 17; i++) step(1, 32'hA000_0000 + i, 0, 0, 0, 0, "rx fill");
        chk("R2", "rx full after overflow", {16'h0, rx_status}, 32'h0480);
        // R9: push and read while full; only the read takes effect.
        step(1, 32'hDEAD_BEEF, 1, 0, 0, 0, "R9 rx full both");
        chk("R9", "rx word at full", bus_rx_word, 32'hA000_0000);
        chk("R9", "rx not full after", {31'h0, rx_status[7]}, 32'h0);
        for (int i = 0; i < 16; i++) step(0, 0, 1, 0, 0, 0, "rx drain");
        // R5: read from an empty FIFO, then push and read a new word.
        step(0, 0, 1, 0, 0, 0, "rx read empty");
        chk("R5", "rx hold", bus_rx_word, 32'hA000_000F);
        // R9: push and read together while empty; only the push takes effect.
        step(1, 32'h1234_5678, 1, 0, 0, 0, "R9 rx empty both");
        chk("R9", "rx one word held", {16'h0, rx_status}, 32'h0000);
        step(0, 0, 1, 0, 0, 0, "rx after empty");
        chk("R5", "rx new word", bus_rx_word, 32'h1234_5678);

        // Transmit FIFO fill, overflow, drain and empty pop.
        for (int i = 0; i < 17; i++) step(0, 0, 0, 1, 32'hB000_0000 + i, 0, "tx fill");
        chk("R2", "tx full after overflow", {16'h0, tx_status}, 32'h0480);
        chk("R4", "tx req off when full", {31'h0, tx_dma_req}, 32'h0);
        for (int i = 0; i < 17; i++) step(0, 0, 0, 0, 0, 1, "tx drain");
        chk("R5", "tx hold", card_tx_word, 32'hB000_000F);

        // R9: hold the receive FIFO at 8 words with a push and a read each cycle.
        for (int i = 0; i < 8; i++) step(1, 32'hC000_0000 + i, 0, 0, 0, 0, "rx to eight");
        for (int i = 0; i < 6; i++) step(1, 32'hC100_0000 + i, 1, 0, 0, 0, "R9 rx both");
        chk("R9", "rx req held at eight", {31'h0, rx_dma_req}, 32'h1);

        // Random mixed traffic on both FIFOs.
        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom;
            step(r[1:0] != 0, $urandom, r[3:2] == 0 || r[4],
                 r[6:5] != 0, $urandom, r[8:7] == 0 || r[9], "random");
        end

        // Load both FIFOs, then reset in the middle of traffic.
        for (int i = 0; i < 10; i++) step(1, 32'hE000_0000 + i, 0, 1, 32'hF000_0000 + i, 0, "preload");
        do_reset();
        step(0, 0, 1, 0, 0, 1, "read after reset");
        chk("R8", "rx word after flush", bus_rx_word, 32'h0);
        chk("R8", "tx word after flush", card_tx_word, 32'h0);

        done = 1'b1;
        finish_run();
    end

endmodule